// File: doc/BRIEF.md
# Banked Interrupt Controller Register File

This block gathers 72 level-sensitive interrupt lines into three banks: a small basic bank of 8 lines and two general banks of 32 lines each. Every line has an enable bit. Software sets enable bits through one register per bank and clears them through another. In both cases only the bits written as one have an effect. Software reads back each bank's masked pending state over a plain 32-bit register bus that uses word addresses. A single interrupt request output goes high one clock after any enabled line is active. A storage word for fast-interrupt routing is kept but has no effect on anything.

Lines are numbered globally, with the basic bank first. A combinational next-pending scanner takes the index of the last line that was serviced. It returns the lowest-numbered enabled, active line above that index. This lets a handler walk all pending lines in ascending order with one lookup per step.

The block has no state machine. Its state is the three enable registers, the fast-interrupt storage word and the registered request output. The register bus uses word index `reg_addr` (byte offset = 4 × index). A write happens in any cycle with `reg_wen` high. Read data is combinational from `reg_addr`.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset all enable bits are 0, the fast-interrupt storage word is 0, `irq_out` is 0, and every register in the map reads 0.
- R2: Global line n maps as follows: n in 0..7 is basic bit n, n in 8..39 is bank-1 bit n-8, and n in 40..71 is bank-2 bit n-40. Pending reads return the raw line level ANDed with its enable bit: word 0 is basic (bits 31:8 read 0), word 1 is bank 1, word 2 is bank 2.
- R3: A write to an enable-set word sets every enable bit written as 1 and leaves the bits written as 0 unchanged. Word 6 is basic (data bits 7:0 only), word 4 is bank 1, word 5 is bank 2.
- R4: A write to an enable-clear word clears every enable bit written as 1 and leaves the bits written as 0 unchanged. Word 9 is basic, word 7 is bank 1, word 8 is bank 2.
- R5: Reading either the enable-set word or the enable-clear word of a bank returns that bank's current enable mask. Bits 31:8 read 0 for the basic bank.
- R6: Writes to the pending words 0..2 change no state.
- R7: Word 3 is a 32-bit read/write storage word with no other effect.
- R8: Word indices 10 and above read 0, and writes to them change no state.
- R9: `irq_out` equals the OR of all enabled, active lines, delayed by exactly one clock.
- R10: The scanner starts at `scan_last` + 1, where `scan_last` is signed. A start below 0 is treated as 0. The scanner reports the lowest-numbered enabled, active line at or above the start, with `scan_hit` = 1 and the index on `scan_idx`, in the same cycle.
- R11: When no enabled, active line exists at or above the start (including a start beyond 71), `scan_hit` is 0 and `scan_idx` is 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | 72 | Raw interrupt line levels, global numbering |
| reg_addr | input | 6 | Register word index |
| reg_wen | input | 1 | Write strobe for this cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_out | output | 1 | Registered interrupt request |
| scan_last | input | 8 | Signed index of the last serviced line |
| scan_hit | output | 1 | A pending line was found |
| scan_idx | output | 7 | Found line index, 127 when none |

## Verification
A wrong enable bit is visible in the same cycle at three places: the pending word of its bank, the enable-set and enable-clear read-backs, and the scanner result. It reaches `irq_out` one clock later. An error in the set/clear masking shows in the first read-back after the offending write. A misplaced bank base or a wrong start computation shows as a scanner index off by a bank or by one, and the ascending walk over lines chosen at every bank boundary exposes it at once.

// File: rtl/irq_bank_pkg.sv
`timescale 1ns/1ps
package irq_bank_pkg;

    localparam int BASIC_W   = 8;
    localparam int GEN_W     = 32;
    localparam int GEN_BANKS = 2;
    localparam int NUM_BANKS = GEN_BANKS + 1;
    localparam int NUM_SRC   = BASIC_W + GEN_BANKS * GEN_W;
    localparam int IDX_W     = $clog2(NUM_SRC);
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 6;

    // register word slots; software decodes these positions
    typedef enum logic [ADDR_W-1:0] {
        SLOT_PEND_BASIC = 6'd0,
        SLOT_PEND_G1    = 6'd1,
        SLOT_PEND_G2    = 6'd2,
        SLOT_FAST_STORE = 6'd3,
        SLOT_SET_G1     = 6'd4,
        SLOT_SET_G2     = 6'd5,
        SLOT_SET_BASIC  = 6'd6,
        SLOT_CLR_G1     = 6'd7,
        SLOT_CLR_G2     = 6'd8,
        SLOT_CLR_BASIC  = 6'd9
    } reg_slot_e;

    localparam logic [ADDR_W-1:0] LAST_SLOT = SLOT_CLR_BASIC;

    function automatic int bank_width(input int b);
        return (b == 0) ? BASIC_W : GEN_W;
    endfunction

    function automatic int bank_base(input int b);
        return (b == 0) ? 0 : BASIC_W + (b - 1) * GEN_W;
    endfunction

    function automatic logic [ADDR_W-1:0] pend_slot(input int b);
        return ADDR_W'(b);
    endfunction

    function automatic logic [ADDR_W-1:0] set_slot(input int b);
        return (b == 0) ? SLOT_SET_BASIC : ADDR_W'(SLOT_SET_G1 + b - 1);
    endfunction

    function automatic logic [ADDR_W-1:0] clr_slot(input int b);
        return (b == 0) ? SLOT_CLR_BASIC : ADDR_W'(SLOT_CLR_G1 + b - 1);
    endfunction

endpackage

// File: rtl/irq_bank_enable.sv
`timescale 1ns/1ps
module irq_bank_enable #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wmask,
    output logic [W-1:0] en_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (clr_stb)
            en_q <= en_q & ~wmask;
        else if (set_stb)
            en_q <= en_q | wmask;
    end

    // R3: written ones become enabled
    a_r3_set_bits_on: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb && !clr_stb) |=> ((en_q & $past(wmask)) == $past(wmask)));

    // R3 and R4: zero bits of the mask keep their value
    a_r3_zero_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb || clr_stb) |=> ((en_q & ~$past(wmask)) == ($past(en_q) & ~$past(wmask))));

    // R4: written ones become disabled
    a_r4_clr_bits_off: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((en_q & $past(wmask)) == '0));

    // R6: no strobe, no change
    a_r6_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(en_q));

endmodule

// File: rtl/irq_next_scan.sv
`timescale 1ns/1ps
module irq_next_scan #(
    parameter int N     = 72,
    parameter int IDX_W = 7
) (
    input  logic [N-1:0]      pend,
    input  logic signed [7:0] last,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    int          start;
    logic [N-1:0] cand;

    always_comb begin
        start = int'(last) + 1;
        if (start < 0)
            start = 0;
        for (int i = 0; i < N; i++)
            cand[i] = pend[i] && (i >= start);
    end

    // lowest set candidate wins: walk from the top down
    always_comb begin
        hit = 1'b0;
        idx = '1;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_bank_ctrl.sv
`timescale 1ns/1ps
module irq_bank_ctrl
    import irq_bank_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      src_lvl,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic                    reg_wen,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    output logic                    irq_out,
    input  logic signed [7:0]       scan_last,
    output logic                    scan_hit,
    output logic [IDX_W-1:0]        scan_idx
);

    logic [NUM_SRC-1:0]             en_all;
    logic [NUM_SRC-1:0]             pend_all;
    logic [DATA_W-1:0]              fast_q;
    logic [NUM_BANKS-1:0][DATA_W-1:0] en_word;
    logic [NUM_BANKS-1:0][DATA_W-1:0] pend_word;
    logic                           irq_q;

    assign pend_all = src_lvl & en_all;

    // one enable register per bank
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int BW   = bank_width(b);
        localparam int BASE = bank_base(b);

        logic [BW-1:0] en_b;
        logic          set_b;
        logic          clr_b;

        assign set_b = reg_wen && (reg_addr == set_slot(b));
        assign clr_b = reg_wen && (reg_addr == clr_slot(b));

        irq_bank_enable #(.W(BW)) u_en (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (set_b),
            .clr_stb (clr_b),
            .wmask   (reg_wdata[BW-1:0]),
            .en_q    (en_b)
        );

        assign en_all[BASE +: BW] = en_b;
        assign en_word[b]         = DATA_W'(en_b);
        assign pend_word[b]       = DATA_W'(pend_all[BASE +: BW]);
    end

    // fast-interrupt storage word
    always_ff @(posedge clk) begin
        if (!rst_n)
            fast_q <= '0;
        else if (reg_wen && reg_addr == SLOT_FAST_STORE)
            fast_q <= reg_wdata;
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == SLOT_FAST_STORE)
            reg_rdata = fast_q;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (reg_addr == pend_slot(b))
                reg_rdata = pend_word[b];
            if (reg_addr == set_slot(b) || reg_addr == clr_slot(b))
                reg_rdata = en_word[b];
        end
    end

    // registered request
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |pend_all;
    end
    assign irq_out = irq_q;

    irq_next_scan #(.N(NUM_SRC), .IDX_W(IDX_W)) u_scan (
        .pend (pend_all),
        .last (scan_last),
        .hit  (scan_hit),
        .idx  (scan_idx)
    );

    // R9: a request rises only if some enabled line was active the cycle before
    a_r9_rise_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(|(src_lvl & en_all)));

    // R9: no enabled activity means the request is low next cycle
    a_r9_quiet_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_lvl & en_all) == '0) |=> !irq_out);

    // R10: a reported line is really pending
    a_r10_hit_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
        scan_hit |-> (scan_idx < IDX_W'(NUM_SRC)) && src_lvl[scan_idx] && en_all[scan_idx]);

    // R11: none is encoded as all ones
    a_r11_none_code: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_hit |-> (scan_idx == '1));

    // R8: writes outside the map leave storage alone
    a_r8_outside_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr > LAST_SLOT) |=> ($stable(fast_q) && $stable(en_all)));

    // R7: storage word changes only on a write to its slot
    a_r7_store_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wen && reg_addr == SLOT_FAST_STORE) |=> $stable(fast_q));

endmodule

// File: tb/irq_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_bank_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [71:0] src_lvl = '0;
    logic [5:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;
    logic signed [7:0] scan_last = -8'sd1;
    logic        scan_hit;
    logic [6:0]  scan_idx;

    always #2.5 clk = ~clk;

    irq_bank_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_lvl   (src_lvl),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out),
        .scan_last (scan_last),
        .scan_hit  (scan_hit),
        .scan_idx  (scan_idx)
    );

    // scoreboard item: kind 0 read data, 1 request, 2 scan {hit,idx}
    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    // bench model, built from the requirements
    logic [71:0] en_m = '0;
    logic [31:0] fast_m = '0;

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        logic [71:0] p;
        p = src_lvl & en_m;
        case (a)
            6'd0:       return {24'd0, p[7:0]};
            6'd1:       return p[39:8];
            6'd2:       return p[71:40];
            6'd3:       return fast_m;
            6'd4, 6'd7: return en_m[39:8];
            6'd5, 6'd8: return en_m[71:40];
            6'd6, 6'd9: return {24'd0, en_m[7:0]};
            default:    return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] exp_scan(input int last);
        int s;
        logic [71:0] p;
        p = src_lvl & en_m;
        s = last + 1;
        if (s < 0) s = 0;
        for (int i = s; i < 72; i++)
            if (p[i]) return {24'd0, 1'b1, 7'(i)};
        return {24'd0, 1'b0, 7'h7F};
    endfunction

    // monitor: compare everything queued for this cycle
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                0:       act = reg_rdata;
                1:       act = {31'd0, irq_out};
                default: act = {24'd0, scan_hit, scan_idx};
            endcase
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        q.push_back(it);
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        step();
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        step();
        reg_wen = 1'b0;
        case (a)
            6'd3: fast_m = d;
            6'd4: en_m[39:8]  = en_m[39:8]  | d;
            6'd5: en_m[71:40] = en_m[71:40] | d;
            6'd6: en_m[7:0]   = en_m[7:0]   | d[7:0];
            6'd7: en_m[39:8]  = en_m[39:8]  & ~d;
            6'd8: en_m[71:40] = en_m[71:40] & ~d;
            6'd9: en_m[7:0]   = en_m[7:0]   & ~d[7:0];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        reg_addr = a;
        push(0, exp_read(a), tag);
        settle();
    endtask

    task automatic scan(input int last, input string tag);
        scan_last = 8'(last);
        push(2, exp_scan(last), tag);
        settle();
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        for (int a = 0; a < 10; a++) rd(6'(a), "R1 reset read");
        push(1, 32'd0, "R1 irq low after reset");
        settle();
        scan(-1, "R11 nothing pending after reset");

        // R2: raw lines without enables read zero
        src_lvl = {32'hC000_0003, 32'h8000_F001, 8'h5A};
        step();
        rd(6'd0, "R2 basic masked by zero enables");
        push(1, 32'd0, "R9 no enabled lines");
        settle();

        // R3 / R5: basic enable set and read back through both slots
        wr(6'd6, 32'hFFFF_FFA5);
        rd(6'd6, "R5 basic set-slot read back");
        rd(6'd9, "R5 basic clr-slot read back");
        rd(6'd0, "R2 basic pending word");
        wr(6'd6, 32'h0000_000A);
        rd(6'd6, "R3 zero bits left unchanged");

        // R3: general banks
        wr(6'd4, 32'hF000_0001);
        wr(6'd5, 32'h8000_0010);
        rd(6'd1, "R2 bank1 pending word");
        rd(6'd2, "R2 bank2 pending word");
        rd(6'd7, "R5 bank1 clr-slot read back");

        // R4: clears
        wr(6'd9, 32'h0000_0005);
        rd(6'd6, "R4 basic clear");
        wr(6'd7, 32'h0000_0001);
        rd(6'd4, "R4 bank1 clear leaves others");
        wr(6'd8, 32'h0000_0000);
        rd(6'd5, "R4 zero mask clears nothing");

        // R6: pending writes inert
        wr(6'd1, 32'hFFFF_FFFF);
        wr(6'd0, 32'h0000_0000);
        rd(6'd4, "R6 bank1 enables after pending write");
        rd(6'd6, "R6 basic enables after pending write");
        rd(6'd1, "R6 bank1 pending after pending write");

        // R7: storage word
        wr(6'd3, 32'hDEAD_BEEF);
        rd(6'd3, "R7 storage read back");
        wr(6'd3, 32'h0123_4567);
        rd(6'd3, "R7 storage overwrite");

        // R8: outside the map
        wr(6'd10, 32'hFFFF_FFFF);
        wr(6'd63, 32'hFFFF_FFFF);
        rd(6'd10, "R8 index 10 reads zero");
        rd(6'd63, "R8 index 63 reads zero");
        rd(6'd3, "R8 storage untouched");
        rd(6'd5, "R8 bank2 enables untouched");

        // R10 / R11: scanner walk across bank boundaries
        wr(6'd6, 32'hFF);
        wr(6'd4, 32'hFFFF_FFFF);
        wr(6'd5, 32'hFFFF_FFFF);
        src_lvl = '0;
        src_lvl[3]  = 1'b1;
        src_lvl[8]  = 1'b1;
        src_lvl[39] = 1'b1;
        src_lvl[40] = 1'b1;
        src_lvl[71] = 1'b1;
        step();
        scan(-1, "R10 first from start");
        scan(3, "R10 basic to bank1 boundary");
        scan(8, "R10 bank1 top bit");
        scan(39, "R10 bank2 first bit");
        scan(40, "R10 last line");
        scan(71, "R11 past the last line");
        scan(-50, "R10 negative start clamps to 0");
        scan(100, "R11 start beyond range");
        scan(2, "R10 start equals pending line");

        // R9: request timing
        src_lvl = '0;
        step();
        settle();
        push(1, 32'd0, "R9 quiet lines");
        settle();
        step();
        src_lvl[71] = 1'b1;
        push(1, 32'd0, "R9 still low in change cycle");
        settle();
        push(1, 32'd1, "R9 high one clock later");
        settle();
        wr(6'd8, 32'h8000_0000);
        settle();
        push(1, 32'd0, "R9 drops after disable");
        settle();
        scan(-1, "R11 disabled line not found");

        repeat (3) step();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule